// File: doc/BRIEF.md
# Prioritized Output-Compare Timer

This block is a general-purpose timer with a single 16-bit time base and eight capture/compare channels. The time base advances on ticks from a power-of-two prescaler; a change of division ratio waits until the prescaler passes through zero, so the tick rhythm never breaks mid-period. Each channel is set up either as an output compare, which acts on its pin when the time base equals the channel value, or as an input capture, which latches the time base when a selected edge arrives on its pin.

Channel 7 is the master compare. When it matches, every pin selected in its force mask is driven to a preset level. That level takes priority over the pin's own compare action in the same cycle. Every channel raises a status flag on a match or a capture. An interrupt-enable register gates the flags onto a single request line, bit for bit. A separate pulse accumulator counts rising or falling edges on its own input.

Software reaches all state through a single-cycle register port. Each register is 16 bits wide and is written or read whole in one access. Each channel pin is split into an input, an output value and an output enable.

Top module: `ocp_timer`

## Requirements
- R1: After reset the time base, pulse count, all channel values, flags, pins (ch_out), output enables and irq read zero.
- R2: Register 0 holds enable in bit 0 and a divide select `s` in bits 3:1. When enabled, the time base increments by one per tick, which is once every 2^s clocks. When disabled, it holds.
- R3: A 7-bit prescale counter starts at zero at reset and counts every enabled clock. A tick occurs on a clock where its low `s` bits are all ones. A newly written select is adopted only on a clock at which the prescale counter is zero; until then the old select stays in force.
- R4: The time base is register 6. A write loads all 16 bits in one cycle, and the load takes priority over a tick. A read returns all 16 bits at once.
- R5: Register 1 bit n set makes channel n an output compare. Its channel value is at register 8+n, and its action code is bits 2n+1:2n of register 2, with 00 none, 01 toggle, 10 clear and 11 set. The action is applied on the clock edge at which the time base steps away from the channel value.
- R6: Register 3 bits 7:0 are the master force mask and bits 15:8 are the force levels. When channel 7 compares successfully, each masked pin, channel 7 included, takes its force level. This overrides any compare action of that channel in the same cycle.
- R7: A channel with bit n of register 1 clear is an input capture, and its action code selects the edge: 01 rising, 10 falling, 11 both, 00 none. On a selected edge of ch_in[n], the channel value takes the time base as it stood at that clock, and the pin output does not change.
- R8: Register 5 bit n is the flag of channel n. A compare match or a capture sets it. Writing 1 clears it, and writing 0 leaves it as it is.
- R9: Register 4 bit n enables flag n onto irq. irq is the OR of flags ANDed with enables.
- R10: Register 7 is the pulse accumulator, and a write loads it. Register 0 bit 4 enables counting, and bit 5 selects rising (1) or falling (0) edges of pa_in. The count wraps from FFFF to 0000.
- R11: ch_oe[n] equals bit n of register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ch_in | input | 8 | Channel pin inputs |
| ch_out | output | 8 | Channel pin output levels |
| ch_oe | output | 8 | Channel pin output enables |
| pa_in | input | 1 | Pulse accumulator input |
| irq | output | 1 | Combined enabled-flag request |

## Verification
The assertions take ch_in and pa_in to be already synchronous to clk, so a level held across one rising edge is one sample, and they take a register write to be a one-cycle strobe. The stimulus changes every input only just after a falling edge. It holds pin and pulse levels for whole cycles, and it places channel values where the time base passes them exactly once per test step. The bench keeps an arithmetic model of the prescaler and time base and compares against it on every cycle while sweeping all eight divide selects.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_IOSEL   = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_ACTION  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_MCTL    = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_IMASK   = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_FLAGS   = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_COUNT   = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_PACC    = 4'd7;
    localparam int                ADR_CH_BASE = 8;

    // Two-bit per-channel code: compare action, or capture edge select
    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel_req,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             tick,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [PS_W-1:0]  pcnt;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } tb_st_t;

    tb_st_t          st_d, st_q;
    logic [PS_W-1:0] div_mask;

    always_comb begin
        st_d     = st_q;
        div_mask = ~({PS_W{1'b1}} << st_q.sel);
        tick     = en && ((st_q.pcnt & div_mask) == div_mask);
        if (en) begin
            st_d.pcnt = st_q.pcnt + PS_W'(1);
        end
        // deferred divide change: adopted only at the zero point
        if (st_q.pcnt == '0) begin
            st_d.sel = sel_req;
        end
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R3
    sel_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel != $past(st_q.sel)) |-> ($past(st_q.pcnt) == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ((st_q.cnt == $past(st_q.cnt)) ||
                          (st_q.cnt == CNT_W'($past(st_q.cnt) + CNT_W'(1)))));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             is_oc,
    input  logic [1:0]       mode,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             pin_in,
    input  logic             force_en,
    input  logic             force_val,
    output logic             hit,
    output logic             cap,
    output logic [CNT_W-1:0] value,
    output logic             pin_out
);

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             pin;
        logic             prev;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   rise, fall;

    always_comb begin
        st_d = st_q;
        rise = pin_in & ~st_q.prev;
        fall = ~pin_in & st_q.prev;
        hit  = is_oc & tick & (cnt == st_q.val);
        cap  = ~is_oc & ((mode[0] & rise) | (mode[1] & fall));

        st_d.prev = pin_in;
        if (cap) begin
            st_d.val = cnt;
        end else if (cmp_we) begin
            st_d.val = cmp_wdata;
        end

        // master force outranks the channel's own action
        if (force_en) begin
            st_d.pin = force_val;
        end else if (hit) begin
            case (act_e'(mode))
                ACT_TOGGLE: st_d.pin = ~st_q.pin;
                ACT_CLEAR:  st_d.pin = 1'b0;
                ACT_SET:    st_d.pin = 1'b1;
                default:    st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value   = st_q.val;
    assign pin_out = st_q.pin;

    // R6
    force_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_en |=> (st_q.pin == $past(force_val)));

    // R7
    capture_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_oc && !force_en) |=> $stable(st_q.pin));

endmodule

// File: rtl/tmr_pacc.sv
module tmr_pacc #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rising,
    input  logic             pa_in,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev;
    } pa_st_t;

    pa_st_t st_d, st_q;
    logic   edge_seen;

    always_comb begin
        st_d      = st_q;
        edge_seen = rising ? (pa_in & ~st_q.prev) : (~pa_in & st_q.prev);
        st_d.prev = pa_in;
        if (load) begin
            st_d.cnt = load_val;
        end else if (en && edge_seen) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R10
    pacc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ((st_q.cnt == $past(st_q.cnt)) ||
                          (st_q.cnt == CNT_W'($past(st_q.cnt) + CNT_W'(1)))));

endmodule

// File: rtl/ocp_timer.sv
module ocp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 8,
    parameter int PS_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] ch_in,
    output logic [NUM_CH-1:0] ch_out,
    output logic [NUM_CH-1:0] ch_oe,
    input  logic              pa_in,
    output logic              irq
);

    localparam int SEL_W    = $clog2(PS_W + 1);
    localparam int PA_EN_B  = SEL_W + 1;
    localparam int PA_RISE_B = SEL_W + 2;
    localparam int IDX_W    = $clog2(NUM_CH);
    localparam int MASTER   = NUM_CH - 1;

    typedef struct packed {
        logic                en;
        logic [SEL_W-1:0]    sel;
        logic                pa_en;
        logic                pa_rise;
        logic [NUM_CH-1:0]   iosel;
        logic [2*NUM_CH-1:0] action;
        logic [NUM_CH-1:0]   mmask;
        logic [NUM_CH-1:0]   mdata;
        logic [NUM_CH-1:0]   imask;
        logic [NUM_CH-1:0]   flags;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              tick;
    logic [CNT_W-1:0]  tcnt;
    logic [CNT_W-1:0]  pa_count;
    logic [NUM_CH-1:0] ch_hit, ch_cap, evt, w1c;
    logic [CNT_W-1:0]  ch_val [NUM_CH];
    logic              cnt_load, pa_load;

    assign cnt_load = reg_we && (reg_addr == ADR_COUNT);
    assign pa_load  = reg_we && (reg_addr == ADR_PACC);
    assign evt      = ch_hit | ch_cap;
    assign w1c      = (reg_we && (reg_addr == ADR_FLAGS)) ? reg_wdata[NUM_CH-1:0] : '0;

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            case (reg_addr)
                ADR_CTRL: begin
                    st_d.en      = reg_wdata[0];
                    st_d.sel     = reg_wdata[SEL_W:1];
                    st_d.pa_en   = reg_wdata[PA_EN_B];
                    st_d.pa_rise = reg_wdata[PA_RISE_B];
                end
                ADR_IOSEL:  st_d.iosel  = reg_wdata[NUM_CH-1:0];
                ADR_ACTION: st_d.action = reg_wdata[2*NUM_CH-1:0];
                ADR_MCTL: begin
                    st_d.mmask = reg_wdata[NUM_CH-1:0];
                    st_d.mdata = reg_wdata[2*NUM_CH-1:NUM_CH];
                end
                ADR_IMASK:  st_d.imask  = reg_wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
        // events raise flags; write-one clears
        st_d.flags = (st_q.flags & ~w1c) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL:   reg_rdata = CNT_W'({st_q.pa_rise, st_q.pa_en, st_q.sel, st_q.en});
            ADR_IOSEL:  reg_rdata = CNT_W'(st_q.iosel);
            ADR_ACTION: reg_rdata = CNT_W'(st_q.action);
            ADR_MCTL:   reg_rdata = CNT_W'({st_q.mdata, st_q.mmask});
            ADR_IMASK:  reg_rdata = CNT_W'(st_q.imask);
            ADR_FLAGS:  reg_rdata = CNT_W'(st_q.flags);
            ADR_COUNT:  reg_rdata = tcnt;
            ADR_PACC:   reg_rdata = pa_count;
            default:    reg_rdata = ch_val[reg_addr[IDX_W-1:0]];
        endcase
    end

    tmr_timebase #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W),
        .SEL_W (SEL_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (st_q.en),
        .sel_req  (st_q.sel),
        .load     (cnt_load),
        .load_val (reg_wdata),
        .tick     (tick),
        .cnt      (tcnt)
    );

    tmr_pacc #(
        .CNT_W (CNT_W)
    ) u_pacc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (st_q.pa_en),
        .rising   (st_q.pa_rise),
        .pa_in    (pa_in),
        .load     (pa_load),
        .load_val (reg_wdata),
        .count    (pa_count)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cnt       (tcnt),
            .is_oc     (st_q.iosel[i]),
            .mode      (st_q.action[2*i+1:2*i]),
            .cmp_we    (reg_we && (reg_addr == ADDR_W'(ADR_CH_BASE + i))),
            .cmp_wdata (reg_wdata),
            .pin_in    (ch_in[i]),
            .force_en  (ch_hit[MASTER] & st_q.mmask[i]),
            .force_val (st_q.mdata[i]),
            .hit       (ch_hit[i]),
            .cap       (ch_cap[i]),
            .value     (ch_val[i]),
            .pin_out   (ch_out[i])
        );
    end

    assign ch_oe = st_q.iosel;
    assign irq   = |(st_q.flags & st_q.imask);

    // R8
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.flags & ~$past(st_q.flags) & ~$past(evt)) == '0));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.flags & $past(w1c) & ~$past(evt)) == '0));

endmodule

// File: tb/ocp_timer_bench.sv
module ocp_timer_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd6;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  ch_in = '0;
    logic [7:0]  ch_out, ch_oe;
    logic        pa_in = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ocp_timer u_ocp_timer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_in(ch_in),
        .ch_out(ch_out), .ch_oe(ch_oe), .pa_in(pa_in), .irq(irq)
    );

    // arithmetic model of the prescaler and time base (R2, R3, R4)
    logic [6:0]  m_pcnt, m_mk;
    logic [2:0]  m_sel, m_pend;
    logic        m_en;
    logic [15:0] m_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pcnt <= '0; m_sel <= '0; m_pend <= '0; m_en <= 1'b0; m_cnt <= '0;
        end else begin
            m_mk = ~(7'h7f << m_sel);
            if (m_en) m_pcnt <= m_pcnt + 7'd1;
            if (m_pcnt == 7'd0) m_sel <= m_pend;
            if (reg_we && reg_addr == 4'd6) m_cnt <= reg_wdata;
            else if (m_en && ((m_pcnt & m_mk) == m_mk)) m_cnt <= m_cnt + 16'd1;
            if (reg_we && reg_addr == 4'd0) begin
                m_en   <= reg_wdata[0];
                m_pend <= reg_wdata[3:1];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 4'd6;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
        reg_addr = 4'd6;
    endtask

    task automatic run_cmp(input int n, input string tag);
        int mism = 0;
        logic [15:0] last_a = '0, last_e = '0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #0.2;
            if (reg_rdata !== m_cnt) begin
                mism++; last_a = reg_rdata; last_e = m_cnt;
            end
        end
        check(mism == 0, tag, last_a, last_e);
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        logic [15:0] r;
        for (int k = 0; k < 3000; k++) begin
            rd(4'd6, r);
            if (r == v) return;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            pa_in = 1'b1; step(2);
            pa_in = 1'b0; step(2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v1, v2, act, c;
        logic [7:0]  exp;
        int          md;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd6, v);  check(v == 16'h0, "R1 count", v, 0);
        rd(4'd5, v);  check(v == 16'h0, "R1 flags", v, 0);
        rd(4'd7, v);  check(v == 16'h0, "R1 pacc", v, 0);
        rd(4'd12, v); check(v == 16'h0, "R1 chval", v, 0);
        check(ch_out == 8'h0 && ch_oe == 8'h0 && irq == 1'b0, "R1 pins", {ch_out, ch_oe, 7'd0, irq}, 0);

        // R2/R3 sweep over every divide select against the model
        wr(4'd0, 16'h0001);
        run_cmp(20, "R2 div1");
        for (int s = 1; s < 8; s++) begin
            wr(4'd0, 16'((s << 1) | 1));
            run_cmp(40, "R3 deferred select");
            run_cmp(260, "R2 divide sweep");
        end
        wr(4'd0, 16'h0000);
        run_cmp(50, "R2 hold when disabled");

        // back to divide by one
        wr(4'd0, 16'h0001);
        step(130);
        wr(4'd1, 16'h008F);
        check(ch_oe == 8'h8F, "R11 oe", ch_oe, 8'h8F);
        wr(4'd15, 16'hF000);

        // R5 compare actions, every code on every channel
        exp = 8'h00;
        for (int r = 0; r < 4; r++) begin
            act = '0;
            for (int n = 0; n < 4; n++) act |= 16'(((n + r) % 4) << (2 * n));
            wr(4'd2, act);
            c = 16'h0200 + 16'(r * 16'h40);
            for (int n = 0; n < 4; n++) wr(4'(8 + n), c);
            wr(4'd6, c - 16'd4);
            wait_cnt(c);
            check(ch_out == exp, "R5 before match", ch_out, exp);
            for (int n = 0; n < 4; n++) begin
                md = (n + r) % 4;
                if (md == 1) exp[n] = ~exp[n];
                else if (md == 2) exp[n] = 1'b0;
                else if (md == 3) exp[n] = 1'b1;
            end
            step(1);
            rd(4'd6, v); check(v == c + 16'd1, "R5 count after", v, c + 16'd1);
            check(ch_out == exp, "R5 after match", ch_out, exp);
            rd(4'd5, v); check(v == 16'h000F, "R8 match flags", v, 16'h000F);
            if (r == 0) begin
                wr(4'd5, 16'h0000);
                rd(4'd5, v); check(v == 16'h000F, "R8 write zero ignored", v, 16'h000F);
                wr(4'd5, 16'h000F);
                rd(4'd5, v); check(v == 16'h0000, "R8 write one clears", v, 0);
            end
        end
        wr(4'd5, 16'h00FF);

        // R6 master compare override
        wr(4'd2, 16'h403E);
        wr(4'd3, 16'h898B);
        wr(4'd8, 16'h0400); wr(4'd9, 16'h0400); wr(4'd10, 16'h0400);
        wr(4'd11, 16'h0500); wr(4'd15, 16'h0400);
        wr(4'd6, 16'h03FC);
        wait_cnt(16'h0400);
        check(ch_out == exp, "R6 before master match", ch_out, exp);
        step(1);
        check(ch_out == 8'h8D, "R6 override", ch_out, 8'h8D);
        rd(4'd5, v); check(v == 16'h0087, "R8 master flags", v, 16'h0087);

        // R9 interrupt gating
        check(irq == 1'b0, "R9 masked", irq, 0);
        wr(4'd4, 16'h0080); check(irq == 1'b1, "R9 enable bit7", irq, 1);
        wr(4'd5, 16'h0080); check(irq == 1'b0, "R9 cleared bit7", irq, 0);
        wr(4'd4, 16'h0004); check(irq == 1'b1, "R9 enable bit2", irq, 1);

        // R7 input capture edges
        wr(4'd4, 16'h0000);
        wr(4'd5, 16'h00FF);
        wr(4'd2, 16'h3900);
        wr(4'd6, 16'h1000);
        step(3);
        rd(4'd6, v1);
        ch_in = 8'h70;
        step(1);
        rd(4'd12, v); check(v == v1, "R7 rising capture", v, v1);
        rd(4'd14, v); check(v == v1, "R7 both-edge rise", v, v1);
        rd(4'd13, v); check(v == 16'h0, "R7 falling-only ignores rise", v, 0);
        rd(4'd5, v);  check(v == 16'h0050, "R8 capture flags", v, 16'h0050);
        step(4);
        rd(4'd6, v2);
        ch_in = 8'h00;
        step(1);
        rd(4'd12, v); check(v == v1, "R7 rising-only ignores fall", v, v1);
        rd(4'd13, v); check(v == v2, "R7 falling capture", v, v2);
        rd(4'd14, v); check(v == v2, "R7 both-edge fall", v, v2);
        check(ch_out == 8'h8D, "R7 pins unchanged", ch_out, 8'h8D);

        // R10 pulse accumulator
        wr(4'd0, 16'h0031); pulse(5);
        rd(4'd7, v); check(v == 16'd5, "R10 rising", v, 5);
        wr(4'd0, 16'h0011); pulse(3);
        rd(4'd7, v); check(v == 16'd8, "R10 falling", v, 8);
        wr(4'd0, 16'h0001); pulse(4);
        rd(4'd7, v); check(v == 16'd8, "R10 disabled", v, 8);
        wr(4'd7, 16'hFFFF); wr(4'd0, 16'h0031); pulse(1);
        rd(4'd7, v); check(v == 16'd0, "R10 wrap", v, 0);

        // R4 full-width load and read
        wr(4'd0, 16'h0000);
        wr(4'd6, 16'hABCD);
        rd(4'd6, v); check(v == 16'hABCD, "R4 load", v, 16'hABCD);
        step(10);
        rd(4'd6, v); check(v == 16'hABCD, "R2 hold", v, 16'hABCD);
        wr(4'd0, 16'h0001);
        step(5);
        wr(4'd6, 16'h1234);
        rd(4'd6, v); check(v == 16'h1234, "R4 load while running", v, 16'h1234);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule